// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the byte address of a data load or store from values already read out of the register file. It picks one of three register-indirect modes, adds in 32-bit unsigned arithmetic and drops any carry out of the top bit. It then classifies the access by operand size: it flags an access that is not on its natural boundary, computes the address of the operand's final byte, and shows when that final byte has wrapped past the top of the address space to zero.

It also produces four byte-lane enables for a 32-bit big-endian memory port. Lane enable bit 3 is the most significant byte lane, which holds address offset 0. The enables cover only the lanes of the word that holds the first byte. All results are registered once, so they appear one clock after the request, together with a valid strobe.

Top module: `lsu_ea_gen`

## Requirements
- R1: With `mode` = 0, the address is `src_a` plus `disp` sign-extended from 16 to 32 bits.
- R2: With `mode` = 1, the address is `src_a` plus `src_b`.
- R3: With `mode` = 2 or 3, the address is `src_a` alone, and `src_b` and `disp` have no effect on any output.
- R4: Every sum is taken modulo 2^32, and a carry out of bit 31 is discarded.
- R5: `size` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 selects 4 bytes. `misaligned` is 1 exactly when the address is not a multiple of the operand length.
- R6: `last_addr` equals address + length - 1 modulo 2^32. `wrapped` is 1 exactly when that sum exceeds 0xFFFFFFFF.
- R7: `lane_en` bit (3 - k) is set for each byte offset k, from `addr[1:0]` up to `addr[1:0]` + length - 1, that is no greater than 3. No other bit is set.
- R8: `out_valid` equals `in_valid` from the previous clock. The data outputs load only when `in_valid` is 1 and otherwise hold their value. A synchronous `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Address mode: 0 disp+A, 1 B+A, 2/3 A only |
| size | input | 2 | Operand size: 0 byte, 1 halfword, 2/3 word |
| src_a | input | 32 | Base register value |
| src_b | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| addr | output | 32 | Address of the operand's lowest byte |
| misaligned | output | 1 | Address is off its natural boundary |
| last_addr | output | 32 | Address of the operand's final byte |
| wrapped | output | 1 | Final byte wrapped past the top to zero |
| lane_en | output | 4 | Big-endian byte lanes; bit 3 is offset 0 |

## Verification
There is one register stage, so a wrong mode or size decode shows on `addr`, `last_addr` or `lane_en` on the clock after the request, and never later. A register that loads while `in_valid` is low changes the held outputs on the next edge. A valid strobe that drops from the pipe leaves `out_valid` low one cycle after the request. The wrap and carry cases sit at the top of the address space, so the vectors go up to 0xFFFFFFFF and also cover negative displacements.

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [DW-1:0] disp,
  output logic          out_valid,
  output logic [AW-1:0] addr,
  output logic          misaligned,
  output logic [AW-1:0] last_addr,
  output logic          wrapped,
  output logic [3:0]    lane_en
);

  logic [AW-1:0] disp_x, addend, sum;
  logic [1:0]    len_m1;
  logic [AW:0]   end_w;
  logic [3:0]    mask;

  assign disp_x = {{(AW-DW){disp[DW-1]}}, disp};

  always_comb begin
    case (mode)
      2'd0:    addend = disp_x;
      2'd1:    addend = src_b;
      default: addend = '0;
    endcase
  end

  assign sum = src_a + addend;

  always_comb begin
    case (size)
      2'd0:    begin len_m1 = 2'd0; mask = 4'b1000; end
      2'd1:    begin len_m1 = 2'd1; mask = 4'b1100; end
      default: begin len_m1 = 2'd3; mask = 4'b1111; end
    endcase
  end

  assign end_w = {1'b0, sum} + {{(AW-1){1'b0}}, len_m1};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      addr       <= '0;
      misaligned <= 1'b0;
      last_addr  <= '0;
      wrapped    <= 1'b0;
      lane_en    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr       <= sum;
        misaligned <= (sum[1:0] & len_m1) != 2'd0;
        last_addr  <= end_w[AW-1:0];
        wrapped    <= end_w[AW];
        lane_en    <= mask >> sum[1:0];
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(in_valid) |-> $stable(addr) && $stable(lane_en)); // R8
  AST_SPAN_SMALL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (last_addr - addr) <= 3); // R6
  AST_WRAP_BELOW: assert property (@(posedge clk) disable iff (rst)
    out_valid && wrapped |-> last_addr < addr); // R6
  AST_NOWRAP_ABOVE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !wrapped |-> last_addr >= addr); // R6
  AST_ALIGNED_LOW: assert property (@(posedge clk) disable iff (rst)
    out_valid && !misaligned |-> (addr & (last_addr - addr)) == 0); // R5
  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lane_en[3 - addr[1:0]]); // R7

endmodule

// File: tb/sim_lsu_ea_gen.sv
module sim_lsu_ea_gen;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] mode = 2'd0, size = 2'd0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] disp = '0;
  logic out_valid, misaligned, wrapped;
  logic [31:0] addr, last_addr;
  logic [3:0] lane_en;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lsu_ea_gen u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .size(size),
    .src_a(src_a), .src_b(src_b), .disp(disp), .out_valid(out_valid), .addr(addr),
    .misaligned(misaligned), .last_addr(last_addr), .wrapped(wrapped), .lane_en(lane_en));

  localparam int VW = 122;
  // mode, size, a, b, disp, expected addr, misaligned, wrapped, lanes
  localparam logic [VW-1:0] VEC [13] = '{
    {2'd0, 2'd2, 32'h0000_1000, 32'h0000_DEAD, 16'h0010, 32'h0000_1010, 1'b0, 1'b0, 4'b1111},
    {2'd0, 2'd0, 32'h0000_1000, 32'h0000_0000, 16'hFFFF, 32'h0000_0FFF, 1'b0, 1'b0, 4'b0001},
    {2'd0, 2'd1, 32'h0000_0000, 32'h0000_0004, 16'h8000, 32'hFFFF_8000, 1'b0, 1'b0, 4'b1100},
    {2'd1, 2'd1, 32'h0000_2001, 32'h0000_0002, 16'h1234, 32'h0000_2003, 1'b1, 1'b0, 4'b0001},
    {2'd1, 2'd2, 32'hFFFF_FFF0, 32'h0000_0020, 16'h0000, 32'h0000_0010, 1'b0, 1'b0, 4'b1111},
    {2'd2, 2'd2, 32'h0000_3002, 32'h0000_0055, 16'h0007, 32'h0000_3002, 1'b1, 1'b0, 4'b0011},
    {2'd3, 2'd0, 32'h0000_0001, 32'h0000_0999, 16'h0100, 32'h0000_0001, 1'b0, 1'b0, 4'b0100},
    {2'd2, 2'd2, 32'hFFFF_FFFE, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFE, 1'b1, 1'b1, 4'b0011},
    {2'd2, 2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0001},
    {2'd2, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'b0001},
    {2'd2, 2'd2, 32'hFFFF_FFFC, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFC, 1'b0, 1'b0, 4'b1111},
    {2'd2, 2'd3, 32'h0000_0005, 32'h0000_0000, 16'h0000, 32'h0000_0005, 1'b1, 1'b0, 4'b0111},
    {2'd1, 2'd1, 32'h0000_0002, 32'h0000_0000, 16'h0000, 32'h0000_0002, 1'b0, 1'b0, 4'b0011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] len_of(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic apply(input logic [1:0] m, input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] d);
    @(negedge clk);
    mode = m; size = s; src_a = a; src_b = b; disp = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] hold_addr;
    logic [3:0] hold_lanes;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {31'b0, out_valid}, 32'd0);
    chk("R8 reset addr", addr, 32'd0);
    chk("R8 reset lanes", {28'b0, lane_en}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < 13; i++) begin
      logic [VW-1:0] v;
      logic [32:0] endx;
      v = VEC[i];
      apply(v[121:120], v[119:118], v[117:86], v[85:54], v[53:38]);
      endx = {1'b0, v[37:6]} + {1'b0, len_of(v[119:118])} - 33'd1;
      chk("R8 valid", {31'b0, out_valid}, 32'd1);
      chk("R1 R2 R3 R4 addr", addr, v[37:6]);
      chk("R5 misaligned", {31'b0, misaligned}, {31'b0, v[5]});
      chk("R6 last_addr", last_addr, endx[31:0]);
      chk("R6 wrapped", {31'b0, wrapped}, {31'b0, v[4]});
      chk("R6 wrap model", {31'b0, wrapped}, {31'b0, endx[32]});
      chk("R7 lanes", {28'b0, lane_en}, {28'b0, v[3:0]});
    end

    // R3: src_b and disp ignored in mode 2
    apply(2'd2, 2'd2, 32'h0000_4000, 32'h7777_7777, 16'h8001);
    chk("R3 ignore B/disp", addr, 32'h0000_4000);
    chk("R3 lanes", {28'b0, lane_en}, 32'hF);

    // R8: outputs hold while in_valid is low
    hold_addr = addr; hold_lanes = lane_en;
    @(negedge clk);
    mode = 2'd1; size = 2'd0; src_a = 32'h1234_5673; src_b = 32'h1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle valid", {31'b0, out_valid}, 32'd0);
    chk("R8 hold addr", addr, hold_addr);
    chk("R8 hold lanes", {28'b0, lane_en}, {28'b0, hold_lanes});

    // R8: synchronous reset clears a loaded result
    apply(2'd1, 2'd0, 32'h0000_0010, 32'h0000_0003, 16'h0);
    chk("R7 byte lane", {28'b0, lane_en}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears addr", addr, 32'd0);
    chk("R8 reset clears valid", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule